// File: doc/BRIEF.md
# Self-Programming Command Register

This block is the command and status register that lets software running on the CPU reprogram its own flash. Software first writes a command pattern into the low five bits of the register. An instruction-decoder strobe then fires that command. The strobe only counts if it arrives within a short window after the write. The block turns the armed pattern into one of five actions:

- load one word into the temporary page buffer;
- erase a page;
- write a page;
- set the lock byte;
- reopen the read-while-write region for reading.

Page erase and page write run for a fixed, parameterised number of cycles. A countdown timer stands in for the flash array here. During those operations the block keeps its enable bit high. It latches the target page. Depending on where the page lies, it either raises a read-busy flag or holds the CPU halted. Two further features are provided. While a lock-set command is armed, a program-memory read returns either the lock byte or the fuse byte. A level interrupt tells software when the enable bit has dropped.

The register layout is as follows:

| Bit | Meaning |
|-----|---------|
| 0 | enable |
| 1 | erase |
| 2 | page write |
| 3 | lock set |
| 4 | reopen |
| 5 | reserved, reads zero |
| 6 | read-busy flag (read only) |
| 7 | interrupt enable |

Pages are split into two regions. Pages numbered at or above `NRWW_FIRST_PAGE` form the region that cannot be read during programming. All lower pages form the read-while-write region.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 8'h00, `cpu_halt` and `irq` are low, and `lock_bits` equals `LOCK_INIT`.
- R2: A write updates bits 4:0 only when they hold one of 5'b00001, 5'b00011, 5'b00101, 5'b01001 or 5'b10001. Any other pattern leaves bits 4:0 unchanged. Bit 7 is taken from every write.
- R3: A strobe is accepted only in the four cycles that follow the clock edge at which a legal command was written. If no strobe arrives in those four cycles, bits 4:0 read zero from the fourth edge onward, and a later strobe does nothing.
- R4: An accepted buffer load (5'b00001) pulses `buf_we` in the strobe cycle. It drives `buf_idx` = `prog_addr[WORD_W:1]` (address bit 0 is ignored) and `buf_wdata` = `prog_data`. Bits 4:0 read zero afterwards.
- R5: An accepted erase (5'b00011) or page write (5'b00101) pulses `flash_erase` or `flash_write` respectively. Bits 4:0 keep their value for exactly `PROG_CYCLES` cycles after the strobe edge. `prog_done` is high in the last of those cycles, and the bits then clear.
- R6: An erase or page write to a page below `NRWW_FIRST_PAGE` sets bit 6. Bit 6 stays set after the operation ends. It clears only when a reopen command (5'b10001) is accepted, and that acceptance also pulses `buf_clr`.
- R7: While an erase or page write is running, register writes leave bits 4:0 unchanged, and this includes a reopen command.
- R8: An erase or page write to a page at or above `NRWW_FIRST_PAGE` holds `cpu_halt` high for exactly the `PROG_CYCLES` busy cycles, and it leaves bit 6 clear.
- R9: An accepted lock set (5'b01001) loads `lock_bits` from `prog_data[7:0]`, whatever the address holds.
- R10: While a lock set is armed, `lpm_valid` follows `lpm_strobe` during the first three cycles after the write. In those cycles `lpm_data` is `fuse_bits` when `prog_addr[0]` is 1 and `lock_bits` when it is 0. From the fourth cycle on, `lpm_valid` stays low.
- R11: `irq` is high exactly when bit 7 is set and bit 0 is clear.
- R12: `flash_page` holds the page captured at the strobe, even if `prog_addr` changes during the operation. When a page write completes, `buf_clr` pulses in its `prog_done` cycle.
- R13: Bit 5 reads zero even when it is written as one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe from the CPU |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| prog_strobe | input | 1 | Store-to-program-memory strobe from the decoder |
| prog_addr | input | ADDR_W | Byte address pointer |
| prog_data | input | 16 | Data word for a buffer load (low byte also used for lock data) |
| lpm_strobe | input | 1 | Program-memory read strobe |
| fuse_bits | input | 8 | Fuse byte returned by a lock/fuse read |
| lpm_data | output | 8 | Lock or fuse byte for the read |
| lpm_valid | output | 1 | Read is being served from lock/fuse bits |
| buf_we | output | 1 | Page-buffer word write pulse |
| buf_idx | output | WORD_W | Word index inside the page buffer |
| buf_wdata | output | 16 | Word for the page buffer |
| buf_clr | output | 1 | Page-buffer clear pulse |
| flash_erase | output | 1 | Page erase start pulse |
| flash_write | output | 1 | Page write start pulse |
| flash_page | output | PAGE_W | Latched target page |
| prog_done | output | 1 | Last busy cycle of an erase or write |
| cpu_halt | output | 1 | CPU halt request |
| lock_bits | output | 8 | Current lock byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench exercises the edges of the acceptance window:

- A strobe in the fourth cycle after the write must still fire the command.
- A strobe in the fifth cycle must do nothing.

An off-by-one counter would either reject the first case or accept the second. The bench measures how long erase and page write stay busy, and it checks that `prog_done` falls on the final busy cycle. It also checks that a reopen written mid-operation is refused. A design that let that reopen through would clear the busy flag early or corrupt the running command. Other checks cover the following:

- Illegal and reserved-bit patterns. A careless decoder would arm on these.
- The three-cycle lock/fuse read window.
- The read-busy flag, which must survive the end of the operation. A design that tied it to the timer would drop it without a reopen.

// File: rtl/selfprog_pkg.sv
// Package: shared command type for the self-programming register.
// Assumes: the five command encodings are fixed by the software interface.
package selfprog_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_ERASE,
        OP_WRITE,
        OP_LOCK,
        OP_REOPEN
    } op_e;
endpackage

// File: rtl/selfprog_decode.sv
// Module: maps a five-bit command pattern onto an operation.
// Assumes: every pattern outside the five legal ones means "no operation".
module selfprog_decode
    import selfprog_pkg::*;
(
    input  logic [4:0] pat,
    output op_e        op
);
    // Purpose: pattern to operation lookup.
    always_comb begin
        unique case (pat)
            5'b00001: op = OP_LOAD;
            5'b00011: op = OP_ERASE;
            5'b00101: op = OP_WRITE;
            5'b01001: op = OP_LOCK;
            5'b10001: op = OP_REOPEN;
            default:  op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/selfprog_window.sv
// Module: acceptance window counter. After start, it stays open for WIN cycles.
// Assumes: stop (strobe taken) closes the window. Start has priority over stop.
module selfprog_window #(
    parameter int WIN = 4,
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    output logic          open_o,
    output logic [CW-1:0] left_o
);
    // Purpose: open, count down and close the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            left_o <= '0;
        end else if (start) begin
            open_o <= 1'b1;
            left_o <= CW'(WIN - 1);
        end else if (stop) begin
            open_o <= 1'b0;
        end else if (open_o) begin
            if (left_o == '0) open_o <= 1'b0;
            else              left_o <= left_o - 1'b1;
        end
    end
endmodule

// File: rtl/selfprog_timer.sv
// Module: models the flash programming time with a countdown.
// Assumes: start only arrives while idle. done_o is high during the last busy cycle.
module selfprog_timer #(
    parameter int CYCLES = 64,
    localparam int TW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_o,
    output logic done_o
);
    logic [TW-1:0] cnt_q;

    // Purpose: load the duration on start and count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_o <= 1'b1;
            cnt_q  <= TW'(CYCLES - 1);
        end else if (busy_o) begin
            if (cnt_q == '0) busy_o <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Purpose: flag the final busy cycle.
    assign done_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/selfprog_ctrl.sv
// Module: self-programming command/status register (top).
// It arms a command on a register write, fires it on a strobe within the
// window, and runs erase/write through the timer.
// Assumes: byte addresses, with word index in prog_addr[WORD_W:1] and page
// number above that. Pages at or above NRWW_FIRST_PAGE halt the CPU while
// programmed.
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int         ADDR_W          = 16,
    parameter int         WORD_W          = 7,
    parameter int         NRWW_FIRST_PAGE = 224,
    parameter int         PROG_CYCLES     = 64,
    parameter int         WIN_CYCLES      = 4,
    parameter logic [7:0] LOCK_INIT       = 8'hFF,
    localparam int        PAGE_W          = ADDR_W - WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              prog_strobe,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [15:0]       prog_data,
    input  logic              lpm_strobe,
    input  logic [7:0]        fuse_bits,
    output logic [7:0]        lpm_data,
    output logic              lpm_valid,
    output logic              buf_we,
    output logic [WORD_W-1:0] buf_idx,
    output logic [15:0]       buf_wdata,
    output logic              buf_clr,
    output logic              flash_erase,
    output logic              flash_write,
    output logic [PAGE_W-1:0] flash_page,
    output logic              prog_done,
    output logic              cpu_halt,
    output logic [7:0]        lock_bits,
    output logic              irq
);
    localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

    logic [4:0]        cmd_q;
    logic              irq_en_q, rbusy_q, halt_q;
    logic [PAGE_W-1:0] page_q;
    logic [7:0]        lock_q;
    op_e               wr_op, cur_op;
    logic              win_open;
    logic [CW-1:0]     win_left;
    logic              tmr_busy, tmr_done;
    logic              take, cmd_load, expire, is_prog, in_nrww;
    logic [PAGE_W-1:0] addr_page;

    selfprog_decode u_dec_wr  (.pat(reg_wdata[4:0]), .op(wr_op));
    selfprog_decode u_dec_cur (.pat(cmd_q),          .op(cur_op));

    selfprog_window #(.WIN(WIN_CYCLES)) u_win (
        .clk(clk), .rst_n(rst_n), .start(cmd_load), .stop(take),
        .open_o(win_open), .left_o(win_left)
    );

    selfprog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(take && is_prog),
        .busy_o(tmr_busy), .done_o(tmr_done)
    );

    // Purpose: qualify strobe, write and window-expiry events.
    always_comb begin
        addr_page = prog_addr[ADDR_W-1:WORD_W+1];
        in_nrww   = (int'(addr_page) >= NRWW_FIRST_PAGE);
        is_prog   = (cur_op == OP_ERASE) || (cur_op == OP_WRITE);
        take      = prog_strobe && cmd_q[0] && win_open && !tmr_busy;
        cmd_load  = reg_we && !tmr_busy && !take && (wr_op != OP_NONE);
        expire    = win_open && (win_left == '0) && !take && !cmd_load;
    end

    // Purpose: command bits; load, hold through programming, auto-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cmd_q <= '0;
        else if (cmd_load)            cmd_q <= reg_wdata[4:0];
        else if (take && !is_prog)    cmd_q <= '0;
        else if (tmr_done || expire)  cmd_q <= '0;
    end

    // Purpose: interrupt enable follows every register write.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_en_q <= 1'b0;
        else if (reg_we) irq_en_q <= reg_wdata[7];
    end

    // Purpose: read-busy flag, set by programming the read-while-write region.
    always_ff @(posedge clk) begin
        if (!rst_n)                               rbusy_q <= 1'b0;
        else if (take && is_prog && !in_nrww)     rbusy_q <= 1'b1;
        else if (take && cur_op == OP_REOPEN)     rbusy_q <= 1'b0;
    end

    // Purpose: halt request while the no-read region is being programmed.
    always_ff @(posedge clk) begin
        if (!rst_n)                            halt_q <= 1'b0;
        else if (take && is_prog && in_nrww)   halt_q <= 1'b1;
        else if (tmr_done)                     halt_q <= 1'b0;
    end

    // Purpose: latch the target page when programming starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                 page_q <= '0;
        else if (take && is_prog)   page_q <= addr_page;
    end

    // Purpose: lock byte storage, loaded by the lock-set command.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lock_q <= LOCK_INIT;
        else if (take && cur_op == OP_LOCK) lock_q <= prog_data[7:0];
    end

    // Purpose: drive the outputs from state and qualified events.
    always_comb begin
        reg_rdata   = {irq_en_q, rbusy_q, 1'b0, cmd_q};
        buf_we      = take && (cur_op == OP_LOAD);
        buf_idx     = prog_addr[WORD_W:1];
        buf_wdata   = prog_data;
        buf_clr     = (take && cur_op == OP_REOPEN) || (tmr_done && cmd_q[2]);
        flash_erase = take && (cur_op == OP_ERASE);
        flash_write = take && (cur_op == OP_WRITE);
        flash_page  = page_q;
        prog_done   = tmr_done;
        cpu_halt    = halt_q;
        lock_bits   = lock_q;
        irq         = irq_en_q && !cmd_q[0];
        lpm_valid   = lpm_strobe && (cur_op == OP_LOCK) && win_open && (win_left != '0);
        lpm_data    = prog_addr[0] ? fuse_bits : lock_q;
    end
endmodule

// File: rtl/selfprog_ctrl_chk.sv
// Module: property checker for selfprog_ctrl, attached by bind.
// Assumes: it only observes top-level ports.
module selfprog_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rdata,
    input logic       prog_strobe,
    input logic       buf_we,
    input logic       buf_clr,
    input logic       prog_done,
    input logic       cpu_halt,
    input logic       irq
);
    AST_RSV_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[5] == 1'b0); // R13
    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reg_rdata[4:1])); // R2
    AST_CMD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) (|reg_rdata[4:1]) |-> reg_rdata[0]); // R2
    AST_LOAD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) buf_we |-> (prog_strobe && reg_rdata[0])); // R4
    AST_DONE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n) prog_done |=> !reg_rdata[0]); // R5
    AST_HALT_WHILE_EN: assert property (@(posedge clk) disable iff (!rst_n) cpu_halt |-> reg_rdata[0]); // R8
    AST_BUSY_CLEAR_REOPEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(reg_rdata[6]) |-> $past(buf_clr)); // R6
    AST_IRQ_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !reg_rdata[0]); // R11
endmodule

bind selfprog_ctrl selfprog_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .prog_strobe(prog_strobe),
    .buf_we(buf_we), .buf_clr(buf_clr), .prog_done(prog_done),
    .cpu_halt(cpu_halt), .irq(irq)
);

// File: tb/selfprog_ctrl_tb.sv
// Bench: directed scenarios for selfprog_ctrl, one task each.
module selfprog_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 12;
    localparam int ADDR_W     = 16;
    localparam int WORD_W     = 7;
    localparam int PAGE_W     = ADDR_W - WORD_W - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              prog_strobe = 1'b0;
    logic [ADDR_W-1:0] prog_addr = '0;
    logic [15:0]       prog_data = '0;
    logic              lpm_strobe = 1'b0;
    logic [7:0]        fuse_bits = 8'h5A;
    logic [7:0]        lpm_data;
    logic              lpm_valid, buf_we, buf_clr, flash_erase, flash_write;
    logic [WORD_W-1:0] buf_idx;
    logic [15:0]       buf_wdata;
    logic [PAGE_W-1:0] flash_page;
    logic              prog_done, cpu_halt, irq;
    logic [7:0]        lock_bits;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    selfprog_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NRWW_FIRST_PAGE(224),
                    .PROG_CYCLES(P), .WIN_CYCLES(4), .LOCK_INIT(8'hFF)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .prog_strobe(prog_strobe), .prog_addr(prog_addr),
        .prog_data(prog_data), .lpm_strobe(lpm_strobe), .fuse_bits(fuse_bits),
        .lpm_data(lpm_data), .lpm_valid(lpm_valid), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_clr(buf_clr),
        .flash_erase(flash_erase), .flash_write(flash_write),
        .flash_page(flash_page), .prog_done(prog_done), .cpu_halt(cpu_halt),
        .lock_bits(lock_bits), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write the register: takes effect at the next edge, returns at the following negedge.
    task automatic wr(input logic [7:0] v);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
        chk(!cpu_halt && !irq, "R1 halt/irq", {cpu_halt, irq}, 0);
        chk(lock_bits == 8'hFF, "R1 lock", lock_bits, 8'hFF);
    endtask

    task automatic t_illegal();
        wr(8'h07);
        chk(reg_rdata[4:0] == 5'h00, "R2 pattern 00111", reg_rdata, 0);
        wr(8'h02);
        chk(reg_rdata[4:0] == 5'h00, "R2 pattern 00010", reg_rdata, 0);
        wr(8'h01);
        wr(8'h1F);
        chk(reg_rdata[4:0] == 5'h01, "R2 illegal keeps armed", reg_rdata, 1);
        idle(4);
    endtask

    task automatic t_reserved();
        wr(8'h21);
        chk(reg_rdata == 8'h01, "R13 bit5 zero", reg_rdata, 8'h01);
        idle(4);
    endtask

    task automatic t_load();
        wr(8'h01);
        prog_addr = 16'h0035; prog_data = 16'hBEEF; prog_strobe = 1'b1;
        #1;
        chk(buf_we == 1'b1, "R4 buf_we", buf_we, 1);
        chk(buf_idx == 7'h1A, "R4 index", buf_idx, 7'h1A);
        chk(buf_wdata == 16'hBEEF, "R4 data", buf_wdata, 16'hBEEF);
        @(negedge clk); prog_strobe = 1'b0;
        chk(reg_rdata[4:0] == 5'h00, "R4 clears", reg_rdata, 0);
    endtask

    task automatic t_window_last();
        wr(8'h01);
        idle(3);
        chk(reg_rdata[0] == 1'b1, "R3 armed in 4th cycle", reg_rdata, 1);
        prog_strobe = 1'b1; #1;
        chk(buf_we == 1'b1, "R3 4th cycle accepted", buf_we, 1);
        @(negedge clk); prog_strobe = 1'b0;
    endtask

    task automatic t_window_expire();
        wr(8'h01);
        idle(4);
        chk(reg_rdata[4:0] == 5'h00, "R3 expired", reg_rdata, 0);
        prog_strobe = 1'b1; #1;
        chk(buf_we == 1'b0, "R3 late strobe", buf_we, 0);
        @(negedge clk); prog_strobe = 1'b0;
        wr(8'h03);
        idle(4);
        chk(reg_rdata[4:0] == 5'h00, "R3 erase expired", reg_rdata, 0);
    endtask

    task automatic t_irq();
        wr(8'h80);
        chk(irq == 1'b1, "R11 irq on", irq, 1);
        wr(8'h81);
        chk(irq == 1'b0, "R11 irq off armed", irq, 0);
        idle(4);
        chk(irq == 1'b1, "R11 irq after expiry", irq, 1);
        wr(8'h00);
        chk(irq == 1'b0, "R11 irq disabled", irq, 0);
    endtask

    task automatic t_erase_rww();
        int cnt = 0; int done_at = 0; bit halt_seen = 0;
        wr(8'h03);
        prog_addr = 16'h0500; prog_strobe = 1'b1; #1;
        chk(flash_erase == 1'b1, "R5 erase pulse", flash_erase, 1);
        @(negedge clk); prog_strobe = 1'b0; prog_addr = 16'hFFFF;
        chk(flash_page == 8'h05, "R12 page latched", flash_page, 5);
        chk(reg_rdata[6] == 1'b1, "R6 busy set", reg_rdata, 1);
        while (reg_rdata[0] && cnt < 4*P) begin
            cnt++;
            if (prog_done) done_at = cnt;
            if (cpu_halt) halt_seen = 1;
            if (cnt == 4) chk(reg_rdata[4:0] == 5'h03, "R7 reopen refused", reg_rdata, 3);
            reg_we = (cnt == 2); reg_wdata = 8'h11;
            @(negedge clk);
        end
        reg_we = 1'b0;
        chk(cnt == P, "R5 erase length", cnt, P);
        chk(done_at == P, "R5 done last cycle", done_at, P);
        chk(!halt_seen, "R8 no halt for rww page", halt_seen, 0);
        chk(reg_rdata[6] == 1'b1, "R6 busy after op", reg_rdata, 1);
        prog_addr = '0;
        wr(8'h11);
        prog_strobe = 1'b1; #1;
        chk(buf_clr == 1'b1, "R6 reopen clears buffer", buf_clr, 1);
        @(negedge clk); prog_strobe = 1'b0;
        chk(reg_rdata[6] == 1'b0, "R6 busy cleared", reg_rdata, 0);
    endtask

    task automatic t_write_nrww();
        int cnt = 0; int clr_at = 0; bit busy_seen = 0;
        wr(8'h05);
        prog_addr = 16'hF000; prog_strobe = 1'b1; #1;
        chk(flash_write == 1'b1, "R5 write pulse", flash_write, 1);
        @(negedge clk); prog_strobe = 1'b0; prog_addr = 16'h0000;
        while (cpu_halt && cnt < 4*P) begin
            cnt++;
            if (reg_rdata[6]) busy_seen = 1;
            if (buf_clr) clr_at = cnt;
            @(negedge clk);
        end
        chk(cnt == P, "R8 halt length", cnt, P);
        chk(!busy_seen, "R8 no read-busy", busy_seen, 0);
        chk(clr_at == P, "R12 buffer clear at done", clr_at, P);
        chk(reg_rdata[4:0] == 5'h00, "R5 write clears", reg_rdata, 0);
    endtask

    task automatic t_lock();
        wr(8'h09);
        prog_addr = 16'h1234; prog_data = 16'h77C3; prog_strobe = 1'b1;
        @(negedge clk); prog_strobe = 1'b0;
        chk(lock_bits == 8'hC3, "R9 lock loaded", lock_bits, 8'hC3);
        wr(8'h09);
        lpm_strobe = 1'b1; prog_addr = 16'h0000; #1;
        chk(lpm_valid && lpm_data == 8'hC3, "R10 lock read", {lpm_valid, lpm_data}, 9'h1C3);
        @(negedge clk); prog_addr = 16'h0001; #1;
        chk(lpm_valid && lpm_data == 8'h5A, "R10 fuse read", {lpm_valid, lpm_data}, 9'h15A);
        @(negedge clk); #1;
        chk(lpm_valid == 1'b1, "R10 third cycle", lpm_valid, 1);
        @(negedge clk); #1;
        chk(lpm_valid == 1'b0, "R10 fourth cycle closed", lpm_valid, 0);
        @(negedge clk); lpm_strobe = 1'b0; prog_addr = '0;
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_illegal();
        t_reserved();
        t_load();
        t_window_last();
        t_window_expire();
        t_irq();
        t_erase_rww();
        t_write_nrww();
        t_lock();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule